// File: doc/BRIEF.md
# Mode-Gated Read-Once Secret Store

This block keeps a 256-bit device secret, split into eight 32-bit words, behind a one-way mode flag. After reset the system is in firmware mode. In that mode each secret word may be fetched once, and any later fetch of the same word returns zero. A write to the mode-control location moves the system into application mode. Nothing but reset brings it back. In application mode the whole secret reads as zero.

The bus side takes one request per cycle: a valid strobe, a write flag and a word address. Every request gets a response exactly one cycle later, and no request is ever stalled. A location that is hidden, already consumed or not mapped answers with zero data. The secret value comes in on a static input, because loading it is handled elsewhere. The current mode is driven out on `systemMode` so that other peripherals can gate their own registers with it.

Address map (word addresses, defaults): secret word k sits at `SECRET_BASE + k` (8 to 15), and the mode-control location sits at `MODE_ADDR` (16).

Top module: `secret_vault`

## Requirements
- R1: After reset, `systemMode` is 0, `respValid` is 0, and every secret word is unconsumed.
- R2: In firmware mode, the first read of address `SECRET_BASE+k` returns bits `[32k+31:32k]` of `secretWords`, with `respValid` high, in the cycle after the request.
- R3: A second or later read of the same secret word returns zero. Reading one word does not consume any other word.
- R4: A write to `MODE_ADDR` in firmware mode sets `systemMode` to 1 from the cycle after the request.
- R5: A read of `MODE_ADDR` returns 32'h0000_0000 in firmware mode and 32'hFFFF_FFFF in application mode.
- R6: In application mode, a read of any secret word returns zero, including words never read before.
- R7: Application mode is sticky. Further writes to `MODE_ADDR` leave it set, and only reset returns the block to firmware mode with all words unconsumed.
- R8: Every request, read or write, gives `respValid` exactly one cycle later. A cycle without a request gives no response. Write responses and reads of unmapped addresses carry zero data.
- R9: A write to a secret-word address is ignored and does not consume that word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| secretWords | input | 256 | Device secret; word k in bits [32k+31:32k] |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 6 | Word address |
| respValid | output | 1 | Response for the previous cycle's request |
| respRdata | output | 32 | Read data; zero for writes and for gated locations |
| systemMode | output | 1 | 0 = firmware mode, 1 = application mode |

## Verification
The assertions assume that `secretWords` stays constant after reset and that `reqWrite` and `reqAddr` only matter while `reqValid` is high. They also assume that each clock cycle carries at most one request. The bench drives a fixed secret pattern and changes request inputs only on the falling clock edge. It issues each request as a single-cycle pulse, and for that reason every response can be matched to exactly one earlier request.

// File: rtl/secret_vault_pkg.sv
package secret_vault_pkg;
  parameter int unsigned VaultWords = 8;
  localparam int unsigned VaultIdxW = $clog2(VaultWords);

  typedef struct packed {
    logic                 load;     // a response is owed next cycle
    logic                 grant;    // secret word may be returned
    logic [VaultIdxW-1:0] idx;      // which secret word
    logic                 modeRd;   // mode-control read
    logic                 modeOnes; // current mode value for that read
  } vault_strobe_t;
endpackage

// File: rtl/secret_vault_ctrl.sv
module secret_vault_ctrl
  import secret_vault_pkg::*;
#(
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned SECRET_BASE = 8,
  parameter int unsigned MODE_ADDR   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  output vault_strobe_t     strobe,
  output logic              appMode
);
  localparam logic [ADDR_W-1:0] BaseA = ADDR_W'(SECRET_BASE);
  localparam logic [ADDR_W-1:0] LastA = ADDR_W'(SECRET_BASE + VaultWords - 1);
  localparam logic [ADDR_W-1:0] ModeA = ADDR_W'(MODE_ADDR);

  logic [VaultWords-1:0] usedFlags;
  logic                  inRange;
  logic [ADDR_W-1:0]     offset;
  logic [VaultIdxW-1:0]  wordIdx;
  logic                  grantNow;
  logic                  modeWrite;

  always_comb begin
    inRange   = (reqAddr >= BaseA) && (reqAddr <= LastA);
    offset    = reqAddr - BaseA;
    wordIdx   = offset[VaultIdxW-1:0];
    grantNow  = reqValid && !reqWrite && inRange && !appMode && !usedFlags[wordIdx];
    modeWrite = reqValid && reqWrite && (reqAddr == ModeA) && !appMode;

    strobe.load     = reqValid;
    strobe.grant    = grantNow;
    strobe.idx      = wordIdx;
    strobe.modeRd   = reqValid && !reqWrite && (reqAddr == ModeA);
    strobe.modeOnes = appMode;
  end

  // One-way mode flag: firmware (0) to application (1)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          appMode <= 1'b0;
    else if (modeWrite) appMode <= 1'b1;
  end

  // Per-word sticky consumed flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         usedFlags <= '0;
    else if (grantNow) usedFlags[wordIdx] <= 1'b1;
  end

  assert_mode_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    appMode |=> appMode);

  assert_mode_set_R4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && reqAddr == ModeA) |=> appMode);

  assert_flags_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(usedFlags) & ~usedFlags) == '0));

  assert_no_grant_app_R6: assert property (@(posedge clk) disable iff (!rstN)
    appMode |-> !strobe.grant);
endmodule

// File: rtl/secret_vault_dp.sv
module secret_vault_dp
  import secret_vault_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [VaultWords*WORD_W-1:0] secretWords,
  input  vault_strobe_t              strobe,
  output logic                       respValid,
  output logic [WORD_W-1:0]          respRdata
);
  logic [WORD_W-1:0] wordArr [VaultWords];
  logic [WORD_W-1:0] nextData;

  for (genvar g = 0; g < VaultWords; g++) begin : g_split
    assign wordArr[g] = secretWords[g*WORD_W +: WORD_W];
  end

  always_comb begin
    if (strobe.grant)       nextData = wordArr[strobe.idx];
    else if (strobe.modeRd) nextData = {WORD_W{strobe.modeOnes}};
    else                    nextData = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respRdata <= '0;
    end else begin
      respValid <= strobe.load;
      respRdata <= nextData;
    end
  end

  assert_resp_follows_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> respValid);

  assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> !respValid);
endmodule

// File: rtl/secret_vault.sv
module secret_vault
  import secret_vault_pkg::*;
#(
  parameter int unsigned WORD_W      = 32,
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned SECRET_BASE = 8,
  parameter int unsigned MODE_ADDR   = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [VaultWords*WORD_W-1:0] secretWords,
  input  logic                         reqValid,
  input  logic                         reqWrite,
  input  logic [ADDR_W-1:0]            reqAddr,
  output logic                         respValid,
  output logic [WORD_W-1:0]            respRdata,
  output logic                         systemMode
);
  localparam logic [ADDR_W-1:0] BaseA = ADDR_W'(SECRET_BASE);
  localparam logic [ADDR_W-1:0] LastA = ADDR_W'(SECRET_BASE + VaultWords - 1);
  localparam logic [ADDR_W-1:0] ModeA = ADDR_W'(MODE_ADDR);

  vault_strobe_t strobe;
  logic          appMode;

  secret_vault_ctrl #(
    .ADDR_W(ADDR_W), .SECRET_BASE(SECRET_BASE), .MODE_ADDR(MODE_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .strobe(strobe), .appMode(appMode)
  );

  secret_vault_dp #(.WORD_W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .secretWords(secretWords), .strobe(strobe),
    .respValid(respValid), .respRdata(respRdata)
  );

  assign systemMode = appMode;

  assert_hidden_in_app_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && reqAddr >= BaseA && reqAddr <= LastA && systemMode)
    |=> respRdata == '0);

  assert_mode_read_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && reqAddr == ModeA) |=> respRdata == {WORD_W{systemMode}});

  assert_write_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite) |=> respRdata == '0);
endmodule

// File: tb/secret_vault_tb.sv
module secret_vault_tb;
  localparam int ClkPeriod = 10;
  localparam int NumVec    = 13;

  typedef struct packed {
    logic       wr;
    logic [5:0] addr;
    logic [1:0] kind;   // 0 zero, 1 secret word, 2 all ones
    logic [2:0] word;
    logic       mode;   // expected systemMode after the access
    logic [3:0] req;
  } vec_t;

  localparam vec_t Vecs [NumVec] = '{
    '{1'b0, 6'd8,  2'd1, 3'd0, 1'b0, 4'd2},  // R2 first read word0
    '{1'b0, 6'd8,  2'd0, 3'd0, 1'b0, 4'd3},  // R3 repeat read
    '{1'b0, 6'd11, 2'd1, 3'd3, 1'b0, 4'd2},  // R2 word3
    '{1'b1, 6'd12, 2'd0, 3'd0, 1'b0, 4'd9},  // R9 write to secret
    '{1'b0, 6'd12, 2'd1, 3'd4, 1'b0, 4'd9},  // R9 still readable
    '{1'b0, 6'd16, 2'd0, 3'd0, 1'b0, 4'd5},  // R5 mode fw
    '{1'b0, 6'd3,  2'd0, 3'd0, 1'b0, 4'd8},  // R8 unmapped
    '{1'b0, 6'd11, 2'd0, 3'd0, 1'b0, 4'd3},  // R3 word3 consumed
    '{1'b1, 6'd16, 2'd0, 3'd0, 1'b1, 4'd4},  // R4 switch
    '{1'b0, 6'd16, 2'd2, 3'd0, 1'b1, 4'd5},  // R5 mode app
    '{1'b0, 6'd9,  2'd0, 3'd0, 1'b1, 4'd6},  // R6 hidden
    '{1'b1, 6'd16, 2'd0, 3'd0, 1'b1, 4'd7},  // R7 rewrite
    '{1'b0, 6'd16, 2'd2, 3'd0, 1'b1, 4'd7}   // R7 still app
  };

  logic         clk = 0;
  logic         rstN = 0;
  logic [255:0] secretWords;
  logic         reqValid = 0, reqWrite = 0;
  logic [5:0]   reqAddr = '0;
  logic         respValid, systemMode;
  logic [31:0]  respRdata;
  int           checks = 0, fails = 0;
  logic         gotV;
  logic [31:0]  gotD;

  function automatic logic [31:0] secretOf(int k);
    return 32'h5AC3_0000 + 32'h0101_1111 * (k + 1);
  endfunction

  always_comb for (int k = 0; k < 8; k++) secretWords[k*32 +: 32] = secretOf(k);

  always #(ClkPeriod/2) clk = ~clk;

  secret_vault u_dut (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(logic wr, logic [5:0] a);
    @(negedge clk);
    reqValid = 1; reqWrite = wr; reqAddr = a;
    @(negedge clk);
    gotV = respValid; gotD = respRdata;
    reqValid = 0; reqWrite = 0;
  endtask

  initial begin
    repeat (ClkPeriod * 5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] exp;
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1 systemMode", {31'd0, systemMode}, 32'd0);
    check("R1 respValid", {31'd0, respValid}, 32'd0);
    rstN = 1;
    @(negedge clk);
    check("R1 respValid after release", {31'd0, respValid}, 32'd0);

    for (int i = 0; i < NumVec; i++) begin
      access(Vecs[i].wr, Vecs[i].addr);
      case (Vecs[i].kind)
        2'd1:    exp = secretOf(int'(Vecs[i].word));
        2'd2:    exp = 32'hFFFF_FFFF;
        default: exp = 32'h0;
      endcase
      check($sformatf("R%0d vec%0d data", Vecs[i].req, i), gotD, exp);
      check($sformatf("R8 vec%0d valid", i), {31'd0, gotV}, 32'd1);
      check($sformatf("R%0d vec%0d mode", Vecs[i].req, i),
            {31'd0, systemMode}, {31'd0, Vecs[i].mode});
    end

    // R8 idle cycle gives no response
    @(negedge clk);
    check("R8 idle no response", {31'd0, respValid}, 32'd0);

    // R6 last word hidden in app mode
    access(1'b0, 6'd15);
    check("R6 word7 hidden", gotD, 32'd0);

    // R7 reset returns to firmware mode with words fresh
    rstN = 0;
    @(negedge clk);
    rstN = 1;
    check("R7 mode cleared", {31'd0, systemMode}, 32'd0);
    access(1'b0, 6'd8);
    check("R7 word0 fresh after reset", gotD, secretOf(0));
    access(1'b0, 6'd15);
    check("R2 word7 last", gotD, secretOf(7));
    access(1'b0, 6'd15);
    check("R3 word7 consumed", gotD, 32'd0);
    access(1'b0, 6'd9);
    check("R3 word1 unaffected", gotD, secretOf(1));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule